// File: doc/BRIEF.md
# Sensed Interrupt Controller with Cascade Support

This block collects 32 interrupt request lines and turns them into two processor interrupt outputs, one critical and one non-critical. Each source can be programmed separately for edge or level sensing and for either polarity. A detected event is latched in a pending register. Software clears pending bits by writing ones to them. An enable mask decides which pending bits reach the outputs, and a steering mask sends each enabled source to the critical or the non-critical line.

Software reaches the block over a small register bus. The bus has a 4-bit word address, separate read and write strobes, and 32-bit data. Read data appears on the cycle after the read strobe. Source n sits at register bit 31 − n, so source 0 is the most significant bit. Controllers can be chained: the output of a secondary controller feeds one source input of a primary controller. All request inputs are asynchronous, so each passes through a two-stage synchronizer.

Top module: `sense_irq_ctrl`

## Requirements
- R1: After reset, the enable, steering, polarity and trigger registers read 0, and both interrupt outputs are low.
- R2: Source n appears at bit (31 − n) of every per-source register.
- R3: A level source (trigger bit 0) sets its pending bit while its input sits at the active level: high when the polarity bit is 1, low when it is 0. A pending bit never rises without a detected event.
- R4: An edge source (trigger bit 1) sets its pending bit on a rising transition when the polarity bit is 1, or on a falling transition when it is 0. The opposite transition sets nothing.
- R5: Pending register (offset 0x0): each bit written 1 is cleared; each bit written 0 keeps its value.
- R6: A level source whose input is still active sets again on the same edge that clears it, even when the source is disabled.
- R7: Pending bits latch whether or not the source is enabled.
- R8: The masked register (offset 0x6) reads as pending AND enable (offset 0x2), and writes to it have no effect.
- R9: The critical output is the OR of the masked bits selected in the steering register (offset 0x3, 1 = critical). The non-critical output is the OR of the remaining masked bits.
- R10: Offsets 0x7, 0x8 and every unused offset read 0, and writes to them change no register.
- R11: Read data for the address presented with the read strobe is valid on the cycle after the strobe. Enable, steering, polarity (0x4) and trigger (0x5) read back the value written to them.
- R12: A change on a source input reaches the pending register, and so the outputs, on the third rising clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Interrupt request inputs; bit n is source n |
| addr_i | input | 4 | Register word address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the read strobe |
| crit_irq_o | output | 1 | Critical interrupt request |
| norm_irq_o | output | 1 | Non-critical interrupt request |

## Verification
A source change lands in the pending register on the third rising edge after it is driven: two synchronizer stages, then the pending flop. The bench samples the outputs at the falling edges after the second and third rising edges, so it confirms both the silent cycle and the arrival. Register reads are due one cycle after the strobe. The driver queues the expected word when it issues a read, and the monitor compares it at the falling edge that follows the capturing rising edge. After any source change the bench waits four cycles before reading, so every event has settled before its effect is checked.

// File: rtl/sic_pkg.sv
package sic_pkg;
    typedef logic [3:0] reg_addr_t;

    localparam reg_addr_t A_PEND  = 4'h0;
    localparam reg_addr_t A_EN    = 4'h2;
    localparam reg_addr_t A_CRIT  = 4'h3;
    localparam reg_addr_t A_POL   = 4'h4;
    localparam reg_addr_t A_TRIG  = 4'h5;
    localparam reg_addr_t A_MASK  = 4'h6;
    localparam reg_addr_t A_VEC   = 4'h7;
    localparam reg_addr_t A_VCFG  = 4'h8;
endpackage

// File: rtl/sic_sync.sv
// Two-stage synchronizer plus a history stage, with sources reordered into register bit order.
module sic_sync #(
    parameter int NSRC = 32
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [NSRC-1:0] src_i,
    output logic [NSRC-1:0] cur_o,
    output logic [NSRC-1:0] prev_o
);
    typedef struct packed {
        logic [NSRC-1:0] s1;
        logic [NSRC-1:0] s2;
        logic [NSRC-1:0] hist;
    } sync_t;

    sync_t st_d, st_q;
    logic [NSRC-1:0] src_rev;

    // source n lands on register bit NSRC-1-n
    for (genvar n = 0; n < NSRC; n++) begin : g_rev
        assign src_rev[NSRC-1-n] = src_i[n];
    end

    always_comb begin
        st_d      = st_q;
        st_d.s1   = src_rev;
        st_d.s2   = st_q.s1;
        st_d.hist = st_q.s2;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cur_o  = st_q.s2;
    assign prev_o = st_q.hist;
endmodule

// File: rtl/sic_sense.sv
// Per-source event detector: level or edge, either polarity.
module sic_sense #(
    parameter int NSRC = 32
) (
    input  logic [NSRC-1:0] cur_i,
    input  logic [NSRC-1:0] prev_i,
    input  logic [NSRC-1:0] trig_i,
    input  logic [NSRC-1:0] pol_i,
    output logic [NSRC-1:0] set_o
);
    for (genvar b = 0; b < NSRC; b++) begin : g_bit
        logic lvl_act;
        logic edg_act;
        always_comb begin
            lvl_act = (cur_i[b] == pol_i[b]);
            edg_act = pol_i[b] ? (cur_i[b] & ~prev_i[b])
                               : (~cur_i[b] & prev_i[b]);
            set_o[b] = trig_i[b] ? edg_act : lvl_act;
        end
    end
endmodule

// File: rtl/sic_regs.sv
// Register file: pending (write-one-to-clear), enable, steering, polarity, trigger.
module sic_regs
    import sic_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  reg_addr_t       addr_i,
    input  logic            wr_i,
    input  logic            rd_i,
    input  logic [NSRC-1:0] wdata_i,
    input  logic [NSRC-1:0] set_i,
    output logic [NSRC-1:0] rdata_o,
    output logic [NSRC-1:0] pend_o,
    output logic [NSRC-1:0] en_o,
    output logic [NSRC-1:0] crit_o,
    output logic [NSRC-1:0] pol_o,
    output logic [NSRC-1:0] trig_o
);
    typedef struct packed {
        logic [NSRC-1:0] pend;
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] crit;
        logic [NSRC-1:0] pol;
        logic [NSRC-1:0] trig;
        logic [NSRC-1:0] rdata;
    } regs_t;

    regs_t rg_d, rg_q;
    logic [NSRC-1:0] clr_mask;

    always_comb begin
        rg_d     = rg_q;
        clr_mask = '0;
        if (wr_i) begin
            unique case (addr_i)
                A_PEND:  clr_mask   = wdata_i;
                A_EN:    rg_d.en    = wdata_i;
                A_CRIT:  rg_d.crit  = wdata_i;
                A_POL:   rg_d.pol   = wdata_i;
                A_TRIG:  rg_d.trig  = wdata_i;
                default: ;
            endcase
        end
        // a fresh event wins over a clear in the same cycle
        rg_d.pend = (rg_q.pend & ~clr_mask) | set_i;

        rg_d.rdata = '0;
        if (rd_i) begin
            unique case (addr_i)
                A_PEND:  rg_d.rdata = rg_q.pend;
                A_EN:    rg_d.rdata = rg_q.en;
                A_CRIT:  rg_d.rdata = rg_q.crit;
                A_POL:   rg_d.rdata = rg_q.pol;
                A_TRIG:  rg_d.rdata = rg_q.trig;
                A_MASK:  rg_d.rdata = rg_q.pend & rg_q.en;
                default: rg_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rg_q <= '0;
        else         rg_q <= rg_d;
    end

    assign rdata_o = rg_q.rdata;
    assign pend_o  = rg_q.pend;
    assign en_o    = rg_q.en;
    assign crit_o  = rg_q.crit;
    assign pol_o   = rg_q.pol;
    assign trig_o  = rg_q.trig;

    // R6
    reassert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|set_i) |=> ((pend_o & $past(set_i)) == $past(set_i)));

    // R5
    w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && addr_i == A_PEND) |=> ((pend_o & $past(wdata_i) & ~$past(set_i)) == '0));

    // R3
    no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((pend_o & ~$past(pend_o) & ~$past(set_i)) == '0));

    // R10
    vec_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && (addr_i == A_VEC || addr_i == A_VCFG)) |=> (rdata_o == '0));
endmodule

// File: rtl/sense_irq_ctrl.sv
module sense_irq_ctrl
    import sic_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [NSRC-1:0] src_i,
    input  logic [3:0]      addr_i,
    input  logic            wr_i,
    input  logic            rd_i,
    input  logic [NSRC-1:0] wdata_i,
    output logic [NSRC-1:0] rdata_o,
    output logic            crit_irq_o,
    output logic            norm_irq_o
);
    logic [NSRC-1:0] cur, prev, set_vec;
    logic [NSRC-1:0] pend, en, crit, pol, trig;
    logic [NSRC-1:0] masked;

    sic_sync #(.NSRC(NSRC)) u_sync (
        .clk_i (clk_i), .rst_ni(rst_ni), .src_i(src_i),
        .cur_o (cur),   .prev_o(prev)
    );

    sic_sense #(.NSRC(NSRC)) u_sense (
        .cur_i(cur), .prev_i(prev), .trig_i(trig), .pol_i(pol), .set_o(set_vec)
    );

    sic_regs #(.NSRC(NSRC)) u_regs (
        .clk_i  (clk_i),  .rst_ni(rst_ni), .addr_i(addr_i),
        .wr_i   (wr_i),   .rd_i  (rd_i),   .wdata_i(wdata_i),
        .set_i  (set_vec), .rdata_o(rdata_o), .pend_o(pend),
        .en_o   (en),     .crit_o(crit),   .pol_o(pol), .trig_o(trig)
    );

    always_comb begin
        masked     = pend & en;
        crit_irq_o = |(masked & crit);
        norm_irq_o = |(masked & ~crit);
    end

    // R9
    quiet_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en == '0) |-> (!crit_irq_o && !norm_irq_o));

    // R1
    reset_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (!crit_irq_o && !norm_irq_o));
endmodule

// File: tb/sense_irq_ctrl_test.sv
module sense_irq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '1;
    logic [3:0]  addr = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        crit, norm;

    int total = 0;
    int bad = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    sense_irq_ctrl uut (
        .clk_i(clk), .rst_ni(rst_n), .src_i(src), .addr_i(addr),
        .wr_i(wr), .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata),
        .crit_irq_o(crit), .norm_irq_o(norm)
    );

    function automatic logic [31:0] bitof(int n);
        return 32'h8000_0000 >> n;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wreg(logic [3:0] a, logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    // driver: pushes the expected word, then issues the read
    task automatic rreg(logic [3:0] a, logic [31:0] exp, string tag);
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk); addr = a; rd = 1'b1;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    // monitor: read strobe seen at a rising edge, data checked at the next falling edge
    initial begin
        forever begin
            @(posedge clk);
            if (rd) begin
                @(negedge clk);
                check(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1
        check("R1 crit out", {31'd0, crit}, 32'd0);
        check("R1 norm out", {31'd0, norm}, 32'd0);
        rreg(4'h2, 32'h0, "R1 enable");
        rreg(4'h3, 32'h0, "R1 steer");
        rreg(4'h4, 32'h0, "R1 polarity");
        rreg(4'h5, 32'h0, "R1 trigger");
        settle();
        wreg(4'h0, 32'hFFFF_FFFF);
        rreg(4'h0, 32'h0, "R5 clear all");

        // all sources edge, rising
        wreg(4'h5, 32'hFFFF_FFFF);
        wreg(4'h4, 32'hFFFF_FFFF);
        rreg(4'h5, 32'hFFFF_FFFF, "R11 trigger readback");
        settle();
        wreg(4'h0, 32'hFFFF_FFFF);
        @(negedge clk); src[0] = 1'b0; settle();
        rreg(4'h0, 32'h0, "R4 falling ignored when rising selected");
        @(negedge clk); src[0] = 1'b1; settle();
        rreg(4'h0, bitof(0), "R2 R4 source 0 rising");
        @(negedge clk); src[5] = 1'b0; settle();
        @(negedge clk); src[5] = 1'b1; settle();
        rreg(4'h0, bitof(0) | bitof(5), "R2 source 5 bit 26");
        wreg(4'h0, bitof(0));
        rreg(4'h0, bitof(5), "R5 zero bits keep");

        // latency
        wreg(4'h0, 32'hFFFF_FFFF);
        wreg(4'h2, 32'hFFFF_FFFF);
        @(negedge clk); src[3] = 1'b0; settle();
        check("R9 outputs idle", {30'd0, crit, norm}, 32'd0);
        @(negedge clk); src[3] = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R12 no output after two edges", {31'd0, norm}, 32'd0);
        @(negedge clk);
        check("R12 norm out after third edge", {31'd0, norm}, 32'd1);
        check("R9 crit low when not steered", {31'd0, crit}, 32'd0);
        wreg(4'h3, bitof(3));
        @(negedge clk);
        check("R9 crit high when steered", {30'd0, crit, norm}, 32'd2);
        rreg(4'h6, bitof(3), "R8 masked");
        wreg(4'h6, 32'hFFFF_FFFF);
        rreg(4'h0, bitof(3), "R8 masked write ignored");

        // R7
        wreg(4'h2, 32'h0);
        @(negedge clk);
        check("R7 outputs off when disabled", {30'd0, crit, norm}, 32'd0);
        @(negedge clk); src[7] = 1'b0; settle();
        @(negedge clk); src[7] = 1'b1; settle();
        rreg(4'h0, bitof(3) | bitof(7), "R7 latched while disabled");
        rreg(4'h6, 32'h0, "R8 masked zero");

        // level sensing, source 0
        wreg(4'h0, 32'hFFFF_FFFF);
        wreg(4'h5, ~bitof(0));
        settle();
        rreg(4'h0, bitof(0), "R3 level high active");
        wreg(4'h0, bitof(0));
        rreg(4'h0, bitof(0), "R6 reasserts after clear");
        @(negedge clk); src[0] = 1'b0; settle();
        wreg(4'h0, 32'hFFFF_FFFF);
        rreg(4'h0, 32'h0, "R6 clears once inactive");
        wreg(4'h4, ~bitof(0));
        settle();
        rreg(4'h0, bitof(0), "R3 level low active");

        // R10
        wreg(4'h2, 32'h0000_00F0);
        wreg(4'h7, 32'hFFFF_FFFF);
        wreg(4'h8, 32'hFFFF_FFFF);
        wreg(4'hF, 32'hFFFF_FFFF);
        rreg(4'h7, 32'h0, "R10 vector");
        rreg(4'h8, 32'h0, "R10 vector config");
        rreg(4'hF, 32'h0, "R10 unused");
        rreg(4'h2, 32'h0000_00F0, "R10 enable untouched");
        rreg(4'h3, bitof(3), "R11 steer readback");

        repeat (3) @(negedge clk);
        check("queue drained", exp_q.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule